// File: doc/BRIEF.md
# GPIO and pin function multiplexer

This block owns a large bank of general-purpose pins, grouped into collections of eight. Each pin is either a software-controlled GPIO or is given over to one of three peripheral clients. Software programs the block through a small synchronous byte bus. Each collection has an eight-byte register window, and the windows sit at a fixed stride above a base offset.

Inside a window, two bytes hold the 2-bit function select of every pin, one byte holds the drive (output-enable) bits and one byte holds the output-data bits. A read-only byte returns the pin levels after a two-flop synchronizer. The same synchronized levels also go to the clients. On the pad side, every pin takes its output value and enable from its GPIO bits when its select is zero, or from the chosen client otherwise. A pad whose enable is low always shows a low output value.

Top module: `gp_pinmux`

## Requirements
- R1: After reset, every select field, drive bit and output-data bit reads 0, and every `pad_oe` and `pad_out` bit is 0.
- R2: Window byte 0 holds the selects of pins 0..3 and byte 1 holds the selects of pins 4..7. Pin k of a byte uses bits [2k+1:2k]. A byte write replaces only that byte's four fields and reads back unchanged.
- R3: Window byte 2 is the drive register, where bit n set makes pin n an output. With select 0 (GPIO), `pad_oe` of the pin equals its drive bit.
- R4: Window byte 3 is the output-data register. With select 0, `pad_out` equals the data bit when the drive bit is 1 and equals 0 when it is 0. For any pin, `pad_out` is 0 whenever `pad_oe` is 0.
- R5: Select 1, 2 and 3 hand the pad to client A, B and C. `pad_oe` then follows that client's enable input and `pad_out` follows its output input (gated as in R4), and the GPIO bits have no effect.
- R6: `cli_in` and window byte 6 return the pad levels through a two-flop synchronizer. A change on `pad_in` shows on `cli_in` two clock edges later.
- R7: Reads of window bytes 4, 5 and 7, and of addresses outside all windows, return 0. Writes to those addresses and to byte 6 change nothing.
- R8: Collection c occupies bytes 0x20 + 8c to 0x27 + 8c, and bit n of its bytes belongs to pin 8c + n. This holds for the first collection and for the last one (0xA8).
- R9: `bus_rdata` updates on the clock edge that samples a read, and it holds its value through idle cycles and write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 144 | Pad input levels |
| pad_out | output | 144 | Pad output values |
| pad_oe | output | 144 | Pad output enables |
| cli_in | output | 144 | Synchronized pad levels to the clients |
| cla_out | input | 144 | Client A output values |
| cla_oe | input | 144 | Client A output enables |
| clb_out | input | 144 | Client B output values |
| clb_oe | input | 144 | Client B output enables |
| clc_out | input | 144 | Client C output values |
| clc_oe | input | 144 | Client C output enables |

## Verification
A wrong select field shows up as soon as the write cycle ends: the pad moves to the wrong source, or a byte's readback disagrees. A wrong address decode or field position shows the same way, since the bench compares all 144 pad enables and outputs against its model after every write. Stale or misrouted input state shows up on `cli_in` exactly two edges after a pad change, and on the next read of byte 6. A read mux that leaks data shows as non-zero data one cycle after a read of an unmapped byte.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

    localparam int ADDR_W        = 8;
    localparam int PINS_PER_COLL = 8;
    localparam int WIN_SHIFT     = 3;

    localparam logic [2:0] OFF_SEL_LO = 3'd0;
    localparam logic [2:0] OFF_SEL_HI = 3'd1;
    localparam logic [2:0] OFF_DRIVE  = 3'd2;
    localparam logic [2:0] OFF_DOUT   = 3'd3;
    localparam logic [2:0] OFF_PINS   = 3'd6;

    typedef enum logic [1:0] {
        FN_GPIO  = 2'd0,
        FN_CLI_A = 2'd1,
        FN_CLI_B = 2'd2,
        FN_CLI_C = 2'd3
    } fn_sel_e;

    typedef struct packed {
        logic       hit;
        logic [7:0] coll;
        logic [2:0] off;
    } gpm_dec_t;

    typedef struct packed {
        logic out;
        logic oe;
    } pad_drv_t;

    function automatic gpm_dec_t gpm_decode(input logic [ADDR_W-1:0] a,
                                            input int base, input int ncoll);
        gpm_dec_t d;
        int rel;
        rel    = int'(a) - base;
        d.hit  = (rel >= 0) && ((rel >>> WIN_SHIFT) < ncoll);
        d.coll = 8'(rel >>> WIN_SHIFT);
        d.off  = 3'(rel);
        return d;
    endfunction

endpackage

// File: rtl/gpm_sync.sv
module gpm_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/gpm_padmux.sv
module gpm_padmux
    import gpm_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       gpio_out,
    input  logic       gpio_oe,
    input  logic [2:0] cli_out,
    input  logic [2:0] cli_oe,
    output logic       pad_out,
    output logic       pad_oe
);
    pad_drv_t src;

    always_comb begin
        unique case (fn_sel_e'(sel))
            FN_GPIO:  src = '{out: gpio_out,   oe: gpio_oe};
            FN_CLI_A: src = '{out: cli_out[0], oe: cli_oe[0]};
            FN_CLI_B: src = '{out: cli_out[1], oe: cli_oe[1]};
            default:  src = '{out: cli_out[2], oe: cli_oe[2]};
        endcase
    end

    assign pad_oe  = src.oe;
    assign pad_out = src.out & src.oe;
endmodule

// File: rtl/gpm_regbank.sv
module gpm_regbank
    import gpm_pkg::*;
#(
    parameter int NUM_COLL = 18,
    parameter int BASE     = 32,
    localparam int NUM_PINS = NUM_COLL * PINS_PER_COLL
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_lvl,
    output logic [2*NUM_PINS-1:0] sel_flat,
    output logic [NUM_PINS-1:0]   drv,
    output logic [NUM_PINS-1:0]   dout
);
    logic [7:0] sel_lo_q [NUM_COLL];
    logic [7:0] sel_hi_q [NUM_COLL];
    logic [7:0] drv_q    [NUM_COLL];
    logic [7:0] dout_q   [NUM_COLL];
    logic [7:0] rd_val;
    logic [7:0] rdata_q;
    gpm_dec_t   dec;
    logic       wr_hit;

    assign dec    = gpm_decode(bus_addr, BASE, NUM_COLL);
    assign wr_hit = bus_en && bus_we && dec.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_COLL; c++) begin
                sel_lo_q[c] <= '0;
                sel_hi_q[c] <= '0;
                drv_q[c]    <= '0;
                dout_q[c]   <= '0;
            end
        end else if (wr_hit) begin
            for (int c = 0; c < NUM_COLL; c++) begin
                if (dec.coll == 8'(c)) begin
                    case (dec.off)
                        OFF_SEL_LO: sel_lo_q[c] <= bus_wdata;
                        OFF_SEL_HI: sel_hi_q[c] <= bus_wdata;
                        OFF_DRIVE:  drv_q[c]    <= bus_wdata;
                        OFF_DOUT:   dout_q[c]   <= bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int c = 0; c < NUM_COLL; c++) begin
            if (dec.coll == 8'(c)) begin
                case (dec.off)
                    OFF_SEL_LO: rd_val = sel_lo_q[c];
                    OFF_SEL_HI: rd_val = sel_hi_q[c];
                    OFF_DRIVE:  rd_val = drv_q[c];
                    OFF_DOUT:   rd_val = dout_q[c];
                    OFF_PINS:   rd_val = pin_lvl[c*PINS_PER_COLL +: PINS_PER_COLL];
                    default:    rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (bus_en && !bus_we)
            rdata_q <= dec.hit ? rd_val : 8'h00;
    end

    assign bus_rdata = rdata_q;

    for (genvar c = 0; c < NUM_COLL; c++) begin : g_coll
        assign drv[c*PINS_PER_COLL +: PINS_PER_COLL]  = drv_q[c];
        assign dout[c*PINS_PER_COLL +: PINS_PER_COLL] = dout_q[c];
        for (genvar k = 0; k < PINS_PER_COLL; k++) begin : g_pin
            if (k < PINS_PER_COLL / 2) begin : g_lo
                assign sel_flat[2*(c*PINS_PER_COLL+k) +: 2] = sel_lo_q[c][2*k +: 2];
            end else begin : g_hi
                assign sel_flat[2*(c*PINS_PER_COLL+k) +: 2] =
                    sel_hi_q[c][2*(k-PINS_PER_COLL/2) +: 2];
            end
        end
    end
endmodule

// File: rtl/gp_pinmux.sv
module gp_pinmux
    import gpm_pkg::*;
#(
    parameter int NUM_COLL = 18,
    parameter int BASE     = 32,
    localparam int NUM_PINS = NUM_COLL * PINS_PER_COLL
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] cli_in,
    input  logic [NUM_PINS-1:0] cla_out,
    input  logic [NUM_PINS-1:0] cla_oe,
    input  logic [NUM_PINS-1:0] clb_out,
    input  logic [NUM_PINS-1:0] clb_oe,
    input  logic [NUM_PINS-1:0] clc_out,
    input  logic [NUM_PINS-1:0] clc_oe
);
    logic [NUM_PINS-1:0]   pin_lvl;
    logic [2*NUM_PINS-1:0] sel_flat;
    logic [NUM_PINS-1:0]   drv;
    logic [NUM_PINS-1:0]   dout;

    gpm_sync #(.W(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_lvl)
    );

    assign cli_in = pin_lvl;

    gpm_regbank #(.NUM_COLL(NUM_COLL), .BASE(BASE)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_lvl   (pin_lvl),
        .sel_flat  (sel_flat),
        .drv       (drv),
        .dout      (dout)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        gpm_padmux u_mux (
            .sel      (sel_flat[2*p +: 2]),
            .gpio_out (dout[p]),
            .gpio_oe  (drv[p]),
            .cli_out  ({clc_out[p], clb_out[p], cla_out[p]}),
            .cli_oe   ({clc_oe[p],  clb_oe[p],  cla_oe[p]}),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p])
        );
    end
endmodule

// File: rtl/gpm_checker.sv
module gpm_checker
    import gpm_pkg::*;
#(
    parameter int NUM_COLL = 18,
    parameter int BASE     = 32,
    localparam int NUM_PINS = NUM_COLL * PINS_PER_COLL
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_en,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [7:0]          bus_rdata,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] cli_in
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)
            age_q <= '0;
        else if (age_q != 2'd3)
            age_q <= age_q + 2'd1;
    end

    function automatic logic is_unmapped(input logic [ADDR_W-1:0] a);
        int ia;
        ia = int'(a);
        return (ia < BASE) || (ia >= BASE + 8 * NUM_COLL) ||
               (a[2:0] == 3'd4) || (a[2:0] == 3'd5) || (a[2:0] == 3'd7);
    endfunction

    AST_RST_PADS_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0)); // R1

    AST_OE_GATES_OUT: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0); // R4

    AST_SYNC_LAG: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (cli_in == $past(pad_in, 2))); // R6

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd1 && $past(bus_en && !bus_we && is_unmapped(bus_addr)))
        |-> (bus_rdata == 8'h00)); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd1 && !$past(bus_en && !bus_we)) |-> $stable(bus_rdata)); // R9
endmodule

bind gp_pinmux gpm_checker #(.NUM_COLL(NUM_COLL), .BASE(BASE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .cli_in    (cli_in)
);

// File: tb/gp_pinmux_bench.sv
`timescale 1ns/1ps
module gp_pinmux_bench;
    localparam int NC = 18;
    localparam int NP = NC * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]    bus_addr = '0, bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, cli_in;
    logic [NP-1:0] cla_out = '0, cla_oe = '0, clb_out = '0, clb_oe = '0;
    logic [NP-1:0] clc_out = '0, clc_oe = '0;

    always #2 clk = ~clk;

    gp_pinmux u_gp_pinmux (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .cli_in(cli_in),
        .cla_out(cla_out), .cla_oe(cla_oe), .clb_out(clb_out), .clb_oe(clb_oe),
        .clc_out(clc_out), .clc_oe(clc_oe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t q[$];

    logic [1:0]    sel_m [NP];
    logic [NP-1:0] drv_m = '0, dout_m = '0;
    logic [7:0]    last_rd = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        int c;
        if (a < 8'h20 || a >= 8'hB0) return 8'h00;
        c = (int'(a) - 32) / 8;
        case (a[2:0])
            3'd0: return {sel_m[c*8+3], sel_m[c*8+2], sel_m[c*8+1], sel_m[c*8]};
            3'd1: return {sel_m[c*8+7], sel_m[c*8+6], sel_m[c*8+5], sel_m[c*8+4]};
            3'd2: return drv_m[c*8 +: 8];
            3'd3: return dout_m[c*8 +: 8];
            3'd6: return pad_in[c*8 +: 8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_clear();
        for (int p = 0; p < NP; p++) sel_m[p] = 2'd0;
        drv_m  = '0;
        dout_m = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        int c;
        if (a >= 8'h20 && a < 8'hB0) begin
            c = (int'(a) - 32) / 8;
            case (a[2:0])
                3'd0: for (int k = 0; k < 4; k++) sel_m[c*8+k]   = d[2*k +: 2];
                3'd1: for (int k = 0; k < 4; k++) sel_m[c*8+4+k] = d[2*k +: 2];
                3'd2: drv_m[c*8 +: 8]  = d;
                3'd3: dout_m[c*8 +: 8] = d;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.exp = model_rd(a);
        it.tag = tag;
        last_rd = it.exp;
        q.push_back(it);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    always @(posedge clk) begin
        if (bus_en && !bus_we && !rst) begin
            rd_item_t it;
            #1;
            if (q.size() == 0) begin
                check(1'b0, "R9", "unexpected read", '0, '0);
            end else begin
                it = q.pop_front();
                check(bus_rdata == it.exp, it.tag, "rdata", NP'(bus_rdata), NP'(it.exp));
            end
        end
    end

    task automatic check_pads(input string tag);
        logic [NP-1:0] eo, ev;
        for (int p = 0; p < NP; p++) begin
            case (sel_m[p])
                2'd0: begin eo[p] = drv_m[p];  ev[p] = dout_m[p];  end
                2'd1: begin eo[p] = cla_oe[p]; ev[p] = cla_out[p]; end
                2'd2: begin eo[p] = clb_oe[p]; ev[p] = clb_out[p]; end
                default: begin eo[p] = clc_oe[p]; ev[p] = clc_out[p]; end
            endcase
            ev[p] = ev[p] & eo[p];
        end
        check(pad_oe == eo, tag, "pad_oe", pad_oe, eo);
        check(pad_out == ev, tag, "pad_out", pad_out, ev);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", '0, '0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] old_lvl;
        logic [NP-1:0] pat;
        model_clear();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_pads("R1");
        rd(8'h20, "R1"); rd(8'h21, "R1"); rd(8'h22, "R1"); rd(8'h23, "R1");
        rd(8'hA8, "R1"); rd(8'hAB, "R1");

        // R2: select layout, collection 2 at 0x30
        cla_out = '1; cla_oe = '1;
        clb_out = '0; clb_oe = '1;
        clc_out = '1; clc_oe = '0;
        wr(8'h30, 8'hE4);
        rd(8'h30, "R2"); rd(8'h31, "R2");
        check_pads("R5");
        wr(8'h31, 8'h1B);
        rd(8'h30, "R2"); rd(8'h31, "R2");
        check_pads("R5");
        clc_oe = '1;
        #1 check_pads("R5");

        // R3/R4/R5: GPIO bits only matter on select-0 pins
        wr(8'h32, 8'hFF);
        wr(8'h33, 8'h81);
        rd(8'h32, "R3"); rd(8'h33, "R4");
        check_pads("R3");
        wr(8'h32, 8'h01);
        wr(8'h33, 8'h80);
        check_pads("R4");
        wr(8'h33, 8'hFF);
        check_pads("R5");

        // R8: first and last collection windows
        wr(8'h22, 8'hA5);
        wr(8'h23, 8'h0F);
        wr(8'hAA, 8'h5A);
        wr(8'hAB, 8'hFF);
        check_pads("R8");
        rd(8'h22, "R8"); rd(8'hAA, "R8"); rd(8'hAB, "R8");
        wr(8'hA9, 8'hC0);
        check_pads("R8");
        rd(8'hA9, "R8");

        // R7: unmapped space
        wr(8'h24, 8'hFF); wr(8'h25, 8'hFF); wr(8'h27, 8'hFF);
        wr(8'h1F, 8'hFF); wr(8'hB0, 8'hFF); wr(8'hFF, 8'hFF);
        wr(8'h26, 8'hFF);
        check_pads("R7");
        rd(8'h24, "R7"); rd(8'h25, "R7"); rd(8'h27, "R7");
        rd(8'h1F, "R7"); rd(8'hB0, "R7"); rd(8'hFF, "R7");
        rd(8'h26, "R7"); rd(8'h20, "R7"); rd(8'hAA, "R7");

        // R6: synchronizer lag and input register
        pat = '0;
        for (int p = 0; p < NP; p++) pat[p] = ((p * 7) % 3) == 0;
        pat[47:40] = 8'hA5;
        old_lvl = cli_in;
        @(negedge clk);
        pad_in = pat;
        @(negedge clk);
        check(cli_in == old_lvl, "R6", "cli_in after one edge", cli_in, old_lvl);
        @(negedge clk);
        check(cli_in == pat, "R6", "cli_in after two edges", cli_in, pat);
        rd(8'h46, "R6"); rd(8'hAE, "R6"); rd(8'h26, "R6");

        // R9: read data holds over idle and write cycles
        rd(8'h46, "R9");
        wr(8'h33, 8'h00);
        repeat (3) @(negedge clk);
        check(bus_rdata == last_rd, "R9", "rdata hold", NP'(bus_rdata), NP'(last_rd));

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        check_pads("R1");
        rd(8'h30, "R1"); rd(8'h31, "R1"); rd(8'hAA, "R1");

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R9", "pending reads", NP'(q.size()), '0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule